// File: doc/BRIEF.md
# Limit Counter Timer with Per-CPU Interrupt Routing

A memory-mapped timer built around an up-counter, a limit register and a sticky "reached" flag. A prescaler divides the core clock down to the 2 MHz count rate, so the counter advances once every 500 ns when `DIV` matches the core clock. When the counter steps past the programmed limit, it wraps to zero and the reached flag is set. The flag stays set until software either reads the limit register (an acknowledge that also restarts the count) or writes a new limit.

Each instance has a mode input and a CPU index input. A processor-mode instance drives the interrupt line of its own CPU. A system-mode instance, or a processor-mode instance whose index is all ones, drives the shared system interrupt line. A user-mode instance never raises an interrupt, and reading its limit register has no side effect. Both readback words place the count or limit field with its least significant bit at bit 9, keep bits 8..0 at zero, and carry the reached flag in bit 31.

The control core is a three-state machine:
- FREE: the limit is zero.
- ARMED: a nonzero limit is set and the flag is clear.
- FIRED: the flag is set.

Its transitions are:
- FREE→ARMED on a write of a nonzero limit.
- ARMED→FIRED on a count step taken while the counter equals the limit.
- FIRED→ARMED on an acknowledge or on a write of a nonzero limit.
- Any state→FREE on a write of a zero limit.

Top module: `lct_timer`

## Requirements
- R1: After reset the counter, the limit and the flag are zero, `rdata_o` is zero and no interrupt line is high.
- R2: A read with `addr_i`=0 returns the counter in bits [9 +: CNT_W], the flag in bit 31 and zeros in bits 8..0 on the cycle after `rd_en_i`. The counter advances once every `DIV` clocks, and `DIV` clocks after a clear it holds 1.
- R3: With a nonzero limit L, the flag is set on the count step that leaves L, which comes (L+1)·DIV clocks after a clear. At that step the counter wraps to 0 and keeps counting modulo L+1. A counter equal to L does not set the flag.
- R4: The flag is sticky. It appears in bit 31 of both readbacks and is cleared only by an acknowledge or a limit write.
- R5: A read with `addr_i`=1 in mode 0 (processor) or mode 2 (system) returns the limit and the flag as they were before the read. The same edge clears the flag, the counter and the prescaler.
- R6: A read with `addr_i`=1 in mode 1 (user) or mode 3 returns the limit and flag but leaves the counter, prescaler and flag unchanged.
- R7: A write with `addr_i`=1 loads `wdata_i[9 +: CNT_W]` as the limit and clears the counter, prescaler and flag. A write with `addr_i`=0 changes nothing.
- R8: With a zero limit the counter runs freely, wraps from 2^CNT_W−1 to 0, and never sets the flag.
- R9: In modes 1 and 3 every interrupt output stays low, even with the flag set.
- R10: With the flag set, mode 0 and an index below NCPU raise only `irq_cpu_o[index]`. Mode 2, or mode 0 with an all-ones index, raises only `irq_sys_o`. Mode 0 with any other index raises nothing. At most one line is high at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 0 processor, 1 user, 2 system, 3 treated as user |
| cpu_idx_i | input | CPU_W | CPU index for interrupt routing; all ones selects system routing |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe (wins over a read in the same cycle) |
| addr_i | input | 1 | 0 counter word, 1 limit word |
| wdata_i | input | 32 | Write data; limit taken from bits [9 +: CNT_W] |
| rdata_o | output | 32 | Registered read data |
| irq_cpu_o | output | NCPU | Per-CPU local interrupt lines |
| irq_sys_o | output | 1 | System-routed interrupt line |

## Verification
Directed patterns place reads one clock before and exactly at the (L+1)·DIV boundary. These reads separate a strictly-greater compare from a greater-or-equal one. The same patterns run the full-range limit and the zero limit, which separates the wrap-at-limit path from the free-running wrap.

Routing is swept over every mode and over in-range, out-of-range and all-ones indices while the flag is held. Limit reads are issued in each mode to show which ones acknowledge.

A seeded random phase mixes limits, idle gaps and reads of both words against a closed-form model of count and flag as functions of clocks since the last clear. Any drift in prescaler alignment or in the clear paths shows up as a value mismatch.

// File: rtl/lct_pkg.sv
package lct_pkg;

    localparam int FIELD_LSB = 9;
    localparam int FLAG_BIT  = 31;

    typedef enum logic [1:0] {
        MODE_PROC = 2'd0,
        MODE_USER = 2'd1,
        MODE_SYS  = 2'd2,
        MODE_RSVD = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRED = 2'd2
    } state_e;

    // Modes with bit 0 set never acknowledge and never interrupt.
    function automatic logic mode_quiet(input logic [1:0] m);
        return m[0];
    endfunction

endpackage

// File: rtl/lct_prescale.sv
module lct_prescale #(
    parameter int DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV == 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            logic [PW-1:0] cnt_q;
            assign tick = (cnt_q == PW'(DIV - 1));
            always_ff @(posedge clk) begin
                if (!rst_n || clr || tick) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/lct_core.sv
module lct_core
    import lct_pkg::*;
#(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             ack,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] limit,
    output logic             reached
);
    state_e           state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic [CNT_W-1:0] limit_q, limit_d;
    logic             at_limit;

    assign at_limit = (count_q == limit_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE: begin
                if (ld && ld_val != '0) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (ld)                          state_d = (ld_val == '0) ? ST_FREE : ST_ARMED;
                else if (!ack && tick && at_limit) state_d = ST_FIRED;
            end
            ST_FIRED: begin
                if (ld)       state_d = (ld_val == '0) ? ST_FREE : ST_ARMED;
                else if (ack) state_d = ST_ARMED;
            end
            default: state_d = ST_FREE;
        endcase
    end

    always_comb begin
        limit_d = ld ? ld_val : limit_q;
        if (ld || ack) begin
            count_d = '0;
        end else if (tick) begin
            count_d = (state_q != ST_FREE && at_limit) ? '0 : count_q + 1'b1;
        end else begin
            count_d = count_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
            count_q <= '0;
            limit_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            limit_q <= limit_d;
        end
    end

    always_comb begin
        count   = count_q;
        limit   = limit_q;
        reached = (state_q == ST_FIRED);
    end

endmodule

// File: rtl/lct_route.sv
module lct_route
    import lct_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int CPU_W = 3
) (
    input  logic             reached,
    input  logic [1:0]       mode,
    input  logic [CPU_W-1:0] cpu_idx,
    output logic [NCPU-1:0]  irq_cpu,
    output logic             irq_sys
);
    logic proc_m, sys_m, idx_global;

    assign proc_m     = (mode == MODE_PROC);
    assign sys_m      = (mode == MODE_SYS);
    assign idx_global = (cpu_idx == {CPU_W{1'b1}});
    assign irq_sys    = reached && (sys_m || (proc_m && idx_global));

    generate
        for (genvar i = 0; i < NCPU; i++) begin : g_line
            assign irq_cpu[i] = reached && proc_m && !idx_global && (cpu_idx == CPU_W'(i));
        end
    endgenerate

endmodule

// File: rtl/lct_timer.sv
module lct_timer
    import lct_pkg::*;
#(
    parameter int DIV   = 25,
    parameter int CNT_W = 22,
    parameter int NCPU  = 4,
    parameter int CPU_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic [CPU_W-1:0] cpu_idx_i,
    input  logic             rd_en_i,
    input  logic             wr_en_i,
    input  logic             addr_i,
    input  logic [31:0]      wdata_i,
    output logic [31:0]      rdata_o,
    output logic [NCPU-1:0]  irq_cpu_o,
    output logic             irq_sys_o
);
    logic             tick_w, ld_w, ack_w, reached_w;
    logic [CNT_W-1:0] count_w, limit_w, ld_val_w;
    logic [31:0]      word_d;

    assign ld_w     = wr_en_i && addr_i;
    assign ack_w    = rd_en_i && !wr_en_i && addr_i && !mode_quiet(mode_i);
    assign ld_val_w = wdata_i[FIELD_LSB +: CNT_W];

    lct_prescale #(.DIV(DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ld_w || ack_w),
        .tick  (tick_w)
    );

    lct_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_w),
        .ld      (ld_w),
        .ld_val  (ld_val_w),
        .ack     (ack_w),
        .count   (count_w),
        .limit   (limit_w),
        .reached (reached_w)
    );

    lct_route #(.NCPU(NCPU), .CPU_W(CPU_W)) u_route (
        .reached (reached_w),
        .mode    (mode_i),
        .cpu_idx (cpu_idx_i),
        .irq_cpu (irq_cpu_o),
        .irq_sys (irq_sys_o)
    );

    always_comb begin
        word_d = '0;
        word_d[FIELD_LSB +: CNT_W] = addr_i ? limit_w : count_w;
        word_d[FLAG_BIT] = reached_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (rd_en_i) begin
            rdata_o <= word_d;
        end
    end

endmodule

// File: rtl/lct_timer_chk.sv
module lct_timer_chk #(
    parameter int CNT_W = 22,
    parameter int NCPU  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_i,
    input logic             rd_en_i,
    input logic             wr_en_i,
    input logic             addr_i,
    input logic [31:0]      wdata_i,
    input logic [31:0]      rdata_o,
    input logic [NCPU-1:0]  irq_cpu_o,
    input logic             irq_sys_o,
    input logic             tick,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] limit,
    input logic             reached
);
    logic wr_lim, rd_lim, ackn;
    assign wr_lim = wr_en_i && addr_i;
    assign rd_lim = rd_en_i && !wr_en_i && addr_i;
    assign ackn   = rd_lim && !mode_i[0];

    assert_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[8:0] == 9'd0);
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_lim && !ackn) |=> $stable(count));
    assert_rise_on_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!reached && !tick) |=> !reached);
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reached && !wr_lim && !ackn) |=> reached);
    assert_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ackn |=> (!reached && count == '0));
    assert_user_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lim && mode_i[0] && !tick) |=> ($stable(count) && $stable(reached)));
    assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lim |=> (count == '0 && !reached && limit == $past(wdata_i[9 +: CNT_W])));
    assert_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (limit == '0) |-> !reached);
    assert_mute_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i[0] |-> (irq_cpu_o == '0 && !irq_sys_o));
    assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_cpu_o, irq_sys_o}));
    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !reached |-> (irq_cpu_o == '0 && !irq_sys_o));

endmodule

bind lct_timer lct_timer_chk #(.CNT_W(CNT_W), .NCPU(NCPU)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .rd_en_i   (rd_en_i),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .irq_cpu_o (irq_cpu_o),
    .irq_sys_o (irq_sys_o),
    .tick      (tick_w),
    .count     (count_w),
    .limit     (limit_w),
    .reached   (reached_w)
);

// File: tb/tb_lct_timer.sv
module tb_lct_timer;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_T  = 3;
    localparam int CW_T   = 8;
    localparam int NCPU_T = 4;
    localparam int CPUW_T = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        mode_i = 2'd0;
    logic [CPUW_T-1:0] cpu_idx_i = '0;
    logic              rd_en_i = 1'b0;
    logic              wr_en_i = 1'b0;
    logic              addr_i = 1'b0;
    logic [31:0]       wdata_i = '0;
    logic [31:0]       rdata_o;
    logic [NCPU_T-1:0] irq_cpu_o;
    logic              irq_sys_o;

    int checks = 0;
    int errors = 0;
    int n = 0;
    int lim = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lct_timer #(.DIV(DIV_T), .CNT_W(CW_T), .NCPU(NCPU_T), .CPU_W(CPUW_T)) dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cpu_idx_i(cpu_idx_i),
        .rd_en_i(rd_en_i), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .irq_cpu_o(irq_cpu_o), .irq_sys_o(irq_sys_o)
    );

    function automatic int exp_cnt(int e, int l);
        if (l == 0) return (e / DIV_T) % (1 << CW_T);
        return (e / DIV_T) % (l + 1);
    endfunction

    function automatic bit exp_rch(int e, int l);
        return (l != 0) && (e >= (l + 1) * DIV_T);
    endfunction

    function automatic logic [31:0] word(int f, bit r);
        logic [31:0] w;
        w = 32'(f) << 9;
        w[31] = r;
        return w;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        n++;
        @(negedge clk);
    endtask

    task automatic steps(int k);
        for (int i = 0; i < k; i++) step();
    endtask

    task automatic wr(bit a, int v);
        wr_en_i = 1'b1; addr_i = a; wdata_i = 32'(v) << 9;
        step();
        wr_en_i = 1'b0;
        if (a) begin n = 0; lim = v; end
    endtask

    task automatic rd(bit a, output logic [31:0] d);
        rd_en_i = 1'b1; addr_i = a;
        step();
        rd_en_i = 1'b0;
        d = rdata_o;
        if (a && !mode_i[0]) n = 0;
    endtask

    task automatic rd_count(string tag);
        int e;
        logic [31:0] d;
        e = n;
        rd(1'b0, d);
        chk(tag, d, word(exp_cnt(e, lim), exp_rch(e, lim)));
    endtask

    task automatic chk_irq(string tag, logic [NCPU_T:0] exp);
        chk(tag, 32'({irq_cpu_o, irq_sys_o}), 32'(exp));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hang expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int e;
        void'($urandom(32'd1234));
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        // R1 reset state
        chk("R1 rdata", rdata_o, 32'd0);
        chk_irq("R1 irq", '0);
        rd_count("R1 count");
        rd(1'b1, d);
        chk("R1 limit", d, 32'd0);
        // R2 counting rate and field placement
        steps(10);
        rd_count("R2 count after 10");
        steps(DIV_T - 1);
        rd_count("R2 count step");
        // R3 boundary with L=3, processor mode cpu 2
        cpu_idx_i = 3'd2;
        wr(1'b1, 3);
        steps((3 + 1) * DIV_T - 1);
        chk_irq("R3 none before boundary", '0);
        rd_count("R3 at limit not reached");
        chk_irq("R3 irq after passing limit", 5'b01000);
        rd_count("R3 wrapped with flag R4");
        steps(7);
        rd_count("R4 sticky");
        // R10 and R9 routing sweep while flag set
        cpu_idx_i = 3'd7; #1; chk_irq("R10 all-ones index", 5'b00001);
        cpu_idx_i = 3'd5; #1; chk_irq("R10 out of range", 5'b00000);
        cpu_idx_i = 3'd0; #1; chk_irq("R10 cpu0", 5'b00010);
        mode_i = 2'd2;    #1; chk_irq("R10 system mode", 5'b00001);
        mode_i = 2'd1;    #1; chk_irq("R9 user mode", 5'b00000);
        mode_i = 2'd3;    #1; chk_irq("R9 mode3", 5'b00000);
        // R6 user read of limit has no effect
        mode_i = 2'd1;
        rd(1'b1, d);
        chk("R6 user limit read", d, word(3, 1'b1));
        rd_count("R6 state unchanged");
        // R5 acknowledge in processor mode
        mode_i = 2'd0; cpu_idx_i = 3'd1;
        rd(1'b1, d);
        chk("R5 ack returns old", d, word(3, 1'b1));
        chk_irq("R5 irq dropped", '0);
        rd_count("R5 restart from zero");
        // R7 write to count word ignored, limit write clears
        steps(5);
        wr(1'b0, 77);
        rd_count("R7 count write ignored");
        wr(1'b1, 5);
        rd_count("R7 limit write clears");
        mode_i = 2'd1;
        rd(1'b1, d);
        chk("R7 limit loaded", d, word(5, 1'b0));
        mode_i = 2'd0;
        // R8 free running with wrap
        wr(1'b1, 0);
        steps((1 << CW_T) * DIV_T - 1);
        rd_count("R8 top value");
        rd_count("R8 wrapped to zero");
        chk_irq("R8 no irq", '0);
        // R3 full-range limit
        wr(1'b1, (1 << CW_T) - 1);
        steps((1 << CW_T) * DIV_T - 1);
        rd_count("R3 max limit just before");
        rd_count("R3 max limit reached");
        // Randomized mix
        for (int it = 0; it < 60; it++) begin
            int op;
            op = int'($urandom_range(0, 3));
            if (op == 0) wr(1'b1, int'($urandom_range(1, 6)));
            steps(int'($urandom_range(0, 30)));
            if (op == 1) begin
                e = n;
                rd(1'b1, d);
                chk("R5 random ack", d, word(lim, exp_rch(e, lim)));
            end else if (op == 2) begin
                chk_irq("R10 random irq", exp_rch(n, lim) ? 5'b00100 : 5'b00000);
            end else begin
                rd_count("R3 random count");
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule